// File: doc/BRIEF.md
# Multi-Channel Input FIFO Controller

This block gathers sample words arriving from several input channels and funnels them into a single shared receive queue. A processor reaches the queue, and the block's control and status words, over a small synchronous register bus. A channel's word is admitted only when two enables are set: the global enable and that channel's own enable. When several channels offer a word in the same cycle, the lowest-numbered channel wins. At most one word is stored per cycle.

Any admitted word that cannot be stored sets a sticky per-channel overflow flag. There are two ways to empty the queue at once. One is to clear the global enable. The other is to write a self-clearing flush bit.

Reading the data register pops the oldest word. If the queue is empty, the read either stalls the requester through the ready signal or completes at once with a zero result. A control bit picks which.

Top module: `chmerge_fifo`

## Requirements
- R1: After reset, control word 0 (address 0), control word 1 (address 1) and the status word (address 2) all read as 0, and the queue holds no words.
- R2: A word offered on ch_valid[i] is stored only if control word 0 bit 7 (global enable) and control word 1 bit i (channel enable) are both 1. Otherwise it is dropped, and it sets no flag and changes no count.
- R3: Among the channels admitted in one cycle, only the lowest-numbered one is stored, and at most one word enters the queue per cycle.
- R4: Each admitted word that is not stored sets status bit i for its channel i. Two cases apply: the channel lost arbitration, or the queue was full with no pop in that cycle. A set flag stays set until it is cleared.
- R5: A write to address 0 with bit 6 set clears all overflow flags. A flag that is set in the same cycle stays set.
- R6: A write to address 0 that changes bit 7 from 1 to 0 discards every stored word, so the count reads 0 afterwards. Words admitted after re-enabling are read normally.
- R7: A write to address 0 with bit 31 set discards every stored word. Bits 31 and 6 of address 0 always read as 0, while bits 7 and 4 read back their stored value.
- R8: Status bits 31:28 give the number of words stored (0 to 8). Status bits 7:0 are the channel overflow flags.
- R9: With control word 0 bit 4 at 0, a read of address 3 while the queue is empty holds bus_ready at 0 until a word is stored. The read then completes with that word.
- R10: With control word 0 bit 4 at 1, a read of address 3 on an empty queue completes in the same cycle, returns 0 and leaves the count at 0.
- R11: Reads of address 3 return the stored words oldest first, each read removing one word.
- R12: A store and a pop in the same cycle leave the count unchanged, even when the queue is full. A flush in the same cycle as a store discards the word and sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_valid | input | NUM_CH | One-cycle word strobe per channel |
| ch_data | input | NUM_CH*32 | Channel words, channel i in bits 32*i+31:32*i |
| bus_addr | input | 2 | Register address: 0 ctrl0, 1 ctrl1, 2 status, 3 data |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rd | input | 1 | Register read request, held until bus_ready |
| bus_rdata | output | 32 | Read data, valid while bus_rd and bus_ready are high |
| bus_ready | output | 1 | Read completes in a cycle where it is high |

## Verification
The bench offers three admitted channels in one cycle. A design that picked the wrong winner, or stored more than one word, would show a wrong head word or a count other than one. It fills the queue and then pushes and pops together. A design that refused the store when full, or flagged the channel, would show a count of 7 or a stray flag bit.

Flush is tried against a store in the same cycle, and overflow clear against a new overflow in the same cycle. A wrong priority leaves one word behind or loses the fresh flag.

Empty reads are run in both modes. A stalling design that let the read through early, or a no-stall design that popped or returned stale data, shows up as a wrong bus_ready or bus_rdata.

// File: rtl/chmerge_pkg.sv
package chmerge_pkg;
    localparam int BUS_W      = 32;
    localparam int ADDR_W     = 2;
    localparam int DEF_NUM_CH = 8;
    localparam int DEF_DEPTH  = 8;

    // control word 0 bit positions
    localparam int B_GEN      = 7;
    localparam int B_NOSTALL  = 4;
    localparam int B_OVCLR    = 6;
    localparam int B_FLUSH    = 31;
    // status word: count field base
    localparam int ST_CNT_LSB = 28;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL0  = 2'd0,
        REG_CTRL1  = 2'd1,
        REG_STATUS = 2'd2,
        REG_DATA   = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic gen;
        logic nostall;
    } ctrl_t;

    typedef struct packed {
        logic             flush;
        logic             ovclr;
        logic             gen_nxt;
        logic             nostall_nxt;
    } ctrl0_wr_t;

    function automatic ctrl0_wr_t decode_ctrl0(input logic [BUS_W-1:0] d, input logic gen_now);
        ctrl0_wr_t r;
        r.gen_nxt     = d[B_GEN];
        r.nostall_nxt = d[B_NOSTALL];
        r.ovclr       = d[B_OVCLR];
        r.flush       = d[B_FLUSH] | (gen_now & ~d[B_GEN]);
        return r;
    endfunction
endpackage

// File: rtl/chmerge_arb.sv
module chmerge_arb #(
    parameter int N = 8,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic [N-1:0]     grant,
    output logic [IDX_W-1:0] idx,
    output logic             any
);
    always_comb begin
        grant = '0;
        idx   = '0;
        any   = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                idx      = IDX_W'(i);
                any      = 1'b1;
            end
        end
    end
endmodule

// File: rtl/chmerge_store.sv
module chmerge_store #(
    parameter int DEPTH = 8,
    parameter int W     = 32,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic [W-1:0]     wdata,
    input  logic             pop,
    output logic             push_ok,
    output logic [W-1:0]     head,
    output logic [CNT_W-1:0] count,
    output logic             empty
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wptr_q, rptr_q;
    logic [CNT_W-1:0] count_q;
    logic             full, pop_ok;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (count_q == '0);
    assign full    = (count_q == CNT_W'(DEPTH));
    assign pop_ok  = pop & ~empty & ~flush;
    assign push_ok = push & ~flush & (~full | pop_ok);
    assign head    = mem[rptr_q];
    assign count   = count_q;

    always_ff @(posedge clk) begin
        if (push_ok) mem[wptr_q] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wptr_q  <= '0;
            rptr_q  <= '0;
            count_q <= '0;
        end else begin
            if (push_ok) wptr_q <= bump(wptr_q);
            if (pop_ok)  rptr_q <= bump(rptr_q);
            case ({push_ok, pop_ok})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    p_count_bound_r8: assert property (@(posedge clk) disable iff (rst)
        count_q <= CNT_W'(DEPTH));

    p_pushpop_r12: assert property (@(posedge clk) disable iff (rst)
        (push_ok && pop_ok) |=> (count_q == $past(count_q)));
endmodule

// File: rtl/chmerge_flags.sv
module chmerge_flags #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic         clr,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        logic f_q;
        always_ff @(posedge clk) begin
            if (rst)         f_q <= 1'b0;
            else if (set[i]) f_q <= 1'b1;
            else if (clr)    f_q <= 1'b0;
        end
        assign flags[i] = f_q;

        p_sticky_r4: assert property (@(posedge clk) disable iff (rst)
            (f_q && !clr) |=> f_q);
        p_clear_r5: assert property (@(posedge clk) disable iff (rst)
            (clr && !set[i]) |=> !f_q);
    end
endmodule

// File: rtl/chmerge_fifo.sv
module chmerge_fifo
    import chmerge_pkg::*;
#(
    parameter int NUM_CH = DEF_NUM_CH,
    parameter int DEPTH  = DEF_DEPTH,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NUM_CH-1:0]       ch_valid,
    input  logic [NUM_CH*BUS_W-1:0] ch_data,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic                    bus_wr,
    input  logic [BUS_W-1:0]        bus_wdata,
    input  logic                    bus_rd,
    output logic [BUS_W-1:0]        bus_rdata,
    output logic                    bus_ready
);
    ctrl_t             ctrl_q;
    logic [NUM_CH-1:0] chen_q;
    ctrl0_wr_t         c0w;
    logic              wr_c0, wr_c1, flush, ovclr;
    logic [NUM_CH-1:0] admit, grant, lost, flags;
    logic [IDX_W-1:0]  widx;
    logic              want_push, push_ok, rd_data, pop, empty;
    logic [BUS_W-1:0]  head, push_word;
    logic [CNT_W-1:0]  fifo_count;
    logic              wdata_unused;

    assign wdata_unused = ^bus_wdata;

    // register write decode
    assign wr_c0 = bus_wr && (reg_addr_e'(bus_addr) == REG_CTRL0);
    assign wr_c1 = bus_wr && (reg_addr_e'(bus_addr) == REG_CTRL1);
    assign c0w   = decode_ctrl0(bus_wdata, ctrl_q.gen);
    assign flush = wr_c0 && c0w.flush;
    assign ovclr = wr_c0 && c0w.ovclr;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            chen_q <= '0;
        end else begin
            if (wr_c0) begin
                ctrl_q.gen     <= c0w.gen_nxt;
                ctrl_q.nostall <= c0w.nostall_nxt;
            end
            if (wr_c1) chen_q <= bus_wdata[NUM_CH-1:0];
        end
    end

    // admission and arbitration
    assign admit = ch_valid & chen_q & {NUM_CH{ctrl_q.gen}};

    chmerge_arb #(.N(NUM_CH)) u_arb (
        .req   (admit),
        .grant (grant),
        .idx   (widx),
        .any   (want_push)
    );

    assign push_word = ch_data[widx*BUS_W +: BUS_W];

    // processor read side
    assign rd_data   = bus_rd && (reg_addr_e'(bus_addr) == REG_DATA);
    assign pop       = rd_data && !empty;
    assign bus_ready = !rd_data || !empty || ctrl_q.nostall;

    chmerge_store #(.DEPTH(DEPTH), .W(BUS_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .flush   (flush),
        .push    (want_push),
        .wdata   (push_word),
        .pop     (pop),
        .push_ok (push_ok),
        .head    (head),
        .count   (fifo_count),
        .empty   (empty)
    );

    assign lost = flush ? '0 : (admit & ~(grant & {NUM_CH{push_ok}}));

    chmerge_flags #(.N(NUM_CH)) u_flags (
        .clk   (clk),
        .rst   (rst),
        .set   (lost),
        .clr   (ovclr),
        .flags (flags)
    );

    // read mux
    always_comb begin
        bus_rdata = '0;
        case (reg_addr_e'(bus_addr))
            REG_CTRL0: begin
                bus_rdata[B_GEN]     = ctrl_q.gen;
                bus_rdata[B_NOSTALL] = ctrl_q.nostall;
            end
            REG_CTRL1:  bus_rdata[NUM_CH-1:0] = chen_q;
            REG_STATUS: begin
                bus_rdata[ST_CNT_LSB +: CNT_W] = fifo_count;
                bus_rdata[NUM_CH-1:0]          = flags;
            end
            default:    bus_rdata = empty ? '0 : head;
        endcase
    end

    p_admit_r2: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q.gen |=> (fifo_count <= $past(fifo_count)));

    p_one_write_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    p_lowest_first_r3: assert property (@(posedge clk) disable iff (rst)
        (grant != '0) |-> ((admit & (grant - 1'b1)) == '0));

    p_flush_r6: assert property (@(posedge clk) disable iff (rst)
        flush |=> (fifo_count == '0));

    p_stall_r9: assert property (@(posedge clk) disable iff (rst)
        (rd_data && !bus_ready) |-> (fifo_count == '0));

    p_empty_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (rd_data && bus_ready && fifo_count == '0) |-> (bus_rdata == '0));
endmodule

// File: tb/tb_chmerge_fifo.sv
module tb_chmerge_fifo;
    import chmerge_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 8;
    localparam int DEP        = 8;
    localparam int WD_CYCLES  = 5000;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [NCH-1:0]       ch_valid = '0;
    logic [NCH*BUS_W-1:0] ch_data = '0;
    logic [ADDR_W-1:0]    bus_addr = '0;
    logic                 bus_wr = 1'b0;
    logic [BUS_W-1:0]     bus_wdata = '0;
    logic                 bus_rd = 1'b0;
    logic [BUS_W-1:0]     bus_rdata;
    logic                 bus_ready;

    int checks = 0;
    int fails  = 0;
    int seq    = 0;
    bit done   = 1'b0;

    chmerge_fifo #(.NUM_CH(NCH), .DEPTH(DEP)) dut (
        .clk(clk), .rst(rst), .ch_valid(ch_valid), .ch_data(ch_data),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_rdata(bus_rdata), .bus_ready(bus_ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] word_of(int ch, int s);
        return 32'hD000_0000 | ((32'(s) & 32'hFFFF) << 8) | 32'(ch);
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive_data();
        for (int c = 0; c < NCH; c++) ch_data[c*BUS_W +: BUS_W] = word_of(c, seq);
    endtask

    task automatic push(logic [NCH-1:0] mask);
        @(negedge clk);
        drive_data();
        ch_valid = mask;
        @(posedge clk); #1;
        ch_valid = '0;
        seq++;
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        while (!bus_ready) begin
            @(negedge clk); #1;
        end
        d = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(REG_CTRL0, v);  check("R1 ctrl0 after reset", v, 32'h0);
        rd(REG_CTRL1, v);  check("R1 ctrl1 after reset", v, 32'h0);
        rd(REG_STATUS, v); check("R1 status after reset", v, 32'h0);
    endtask

    task automatic t_admit();
        logic [31:0] v;
        int s;
        wr(REG_CTRL1, 32'hFF);
        push(8'h04);
        rd(REG_STATUS, v); check("R2 global enable off", v, 32'h0);
        wr(REG_CTRL0, 32'h80);
        wr(REG_CTRL1, 32'h00);
        push(8'h04);
        rd(REG_STATUS, v); check("R2 channel enable off", v, 32'h0);
        wr(REG_CTRL1, 32'h04);
        s = seq;
        push(8'h0C);
        rd(REG_STATUS, v); check("R2 only enabled channel stored", v, 32'h1000_0000);
        rd(REG_DATA, v);   check("R11 admitted word", v, word_of(2, s));
    endtask

    task automatic t_priority();
        logic [31:0] v;
        int s;
        wr(REG_CTRL1, 32'hFF);
        s = seq;
        push(8'hA4);
        rd(REG_STATUS, v); check("R3 R4 one stored, losers flagged", v, 32'h1000_00A0);
        rd(REG_DATA, v);   check("R3 lowest channel wins", v, word_of(2, s));
        wr(REG_CTRL0, 32'hC0);
        rd(REG_STATUS, v); check("R5 flags cleared", v, 32'h0);
        rd(REG_CTRL0, v);  check("R7 bit6 reads 0", v, 32'h80);
    endtask

    task automatic t_setclr();
        logic [31:0] v;
        int s1, s2;
        s1 = seq;
        push(8'h30);
        s2 = seq;
        @(negedge clk);
        drive_data();
        ch_valid = 8'h03;
        bus_addr = REG_CTRL0; bus_wdata = 32'hC0; bus_wr = 1'b1;
        @(posedge clk); #1;
        ch_valid = '0; bus_wr = 1'b0;
        seq++;
        rd(REG_STATUS, v); check("R5 set wins over clear", v, 32'h2000_0002);
        rd(REG_DATA, v);   check("R11 first of two", v, word_of(4, s1));
        rd(REG_DATA, v);   check("R11 second of two", v, word_of(0, s2));
        wr(REG_CTRL0, 32'hC0);
    endtask

    task automatic t_order();
        logic [31:0] v;
        int s0;
        s0 = seq;
        push(8'h02); push(8'h10); push(8'h01);
        rd(REG_STATUS, v); check("R8 count three", v, 32'h3000_0000);
        rd(REG_DATA, v); check("R11 order 0", v, word_of(1, s0));
        rd(REG_DATA, v); check("R11 order 1", v, word_of(4, s0 + 1));
        rd(REG_DATA, v); check("R11 order 2", v, word_of(0, s0 + 2));
        rd(REG_STATUS, v); check("R8 count back to zero", v, 32'h0);
    endtask

    task automatic t_full();
        logic [31:0] v;
        int base;
        base = seq;
        for (int k = 0; k < DEP; k++) push(8'h01);
        rd(REG_STATUS, v); check("R8 count full", v, 32'h8000_0000);
        push(8'h08);
        rd(REG_STATUS, v); check("R4 full sets flag", v, 32'h8000_0008);
        push(8'h00); push(8'h00);
        rd(REG_STATUS, v); check("R4 flag sticky", v, 32'h8000_0008);
        @(negedge clk);
        drive_data();
        ch_valid = 8'h40;
        bus_addr = REG_DATA; bus_rd = 1'b1;
        #1;
        check("R12 ready on full pop", 32'(bus_ready), 32'h1);
        check("R11 oldest popped", bus_rdata, word_of(0, base));
        @(posedge clk); #1;
        ch_valid = '0; bus_rd = 1'b0;
        seq++;
        rd(REG_STATUS, v); check("R12 push+pop on full", v, 32'h8000_0008);
        wr(REG_CTRL0, 32'h8000_0080);
        rd(REG_STATUS, v); check("R7 flush bit empties", v, 32'h0000_0008);
        rd(REG_CTRL0, v);  check("R7 bit31 reads 0", v, 32'h80);
        @(negedge clk);
        drive_data();
        ch_valid = 8'h01;
        bus_addr = REG_CTRL0; bus_wdata = 32'h8000_0080; bus_wr = 1'b1;
        @(posedge clk); #1;
        ch_valid = '0; bus_wr = 1'b0;
        seq++;
        rd(REG_STATUS, v); check("R12 flush beats push", v, 32'h0000_0008);
        wr(REG_CTRL0, 32'hC0);
    endtask

    task automatic t_fall();
        logic [31:0] v;
        int s;
        push(8'h01); push(8'h02); push(8'h04);
        wr(REG_CTRL0, 32'h00);
        rd(REG_STATUS, v); check("R6 falling enable flush", v, 32'h0);
        wr(REG_CTRL0, 32'h80);
        rd(REG_STATUS, v); check("R6 still empty after re-enable", v, 32'h0);
        s = seq;
        push(8'h20);
        rd(REG_DATA, v); check("R6 fresh word after re-enable", v, word_of(5, s));
    endtask

    task automatic t_nostall();
        logic [31:0] v;
        int s;
        wr(REG_CTRL0, 32'h90);
        rd(REG_CTRL0, v); check("R7 stall-disable reads back", v, 32'h90);
        @(negedge clk);
        bus_addr = REG_DATA; bus_rd = 1'b1;
        #1;
        check("R10 empty read ready", 32'(bus_ready), 32'h1);
        check("R10 empty read zero", bus_rdata, 32'h0);
        @(posedge clk); #1;
        bus_rd = 1'b0;
        rd(REG_STATUS, v); check("R10 count unchanged", v, 32'h0);
        s = seq;
        push(8'h80);
        rd(REG_DATA, v); check("R10 normal read after", v, word_of(7, s));
    endtask

    task automatic t_stall();
        logic [31:0] v;
        int s;
        wr(REG_CTRL0, 32'h80);
        @(negedge clk);
        bus_addr = REG_DATA; bus_rd = 1'b1;
        #1;
        check("R9 stalled at start", 32'(bus_ready), 32'h0);
        for (int k = 0; k < 2; k++) begin
            @(negedge clk); #1;
            check("R9 still stalled", 32'(bus_ready), 32'h0);
        end
        s = seq;
        drive_data();
        ch_valid = 8'h20;
        @(posedge clk); #1;
        ch_valid = '0;
        seq++;
        @(negedge clk); #1;
        check("R9 released", 32'(bus_ready), 32'h1);
        check("R9 returns arriving word", bus_rdata, word_of(5, s));
        @(posedge clk); #1;
        bus_rd = 1'b0;
        rd(REG_STATUS, v); check("R9 word consumed", v, 32'h0);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_admit();
        t_priority();
        t_setclr();
        t_order();
        t_full();
        t_fall();
        t_nostall();
        t_stall();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule